// File: doc/BRIEF.md
# Timer Compare Output Pin Unit

This block owns one timer waveform output bit and the pin multiplexer in front of it. An external counter sends a one-cycle compare-match pulse. On that pulse the block reads a 2-bit output-action field and sets, clears or toggles the waveform flip-flop, or leaves it alone. In non-PWM operation a force strobe carries out the same action at once, with no match needed. When the action field is nonzero, the waveform bit takes the place of the general-purpose port data on the pin. The pin's output enable always comes from a separate direction bit.

A new action field has no effect at the moment it is written. The block copies the field into an effective copy only on a compare match, or on a force strobe in non-PWM operation. The pin override follows that effective copy. A load input puts a starting level into the waveform flip-flop, so the pin can show a known level before the override is turned on.

Top module: `cmp_out_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `wave_bit` is 0 and the effective action is 00, so `pin_out` equals `port_data`.
- R2: `pin_oe` equals `port_dir` in every cycle, whatever the action field, the PWM input or the waveform state.
- R3: When the effective action is nonzero, `pin_out` equals `wave_bit`. When it is 00, `pin_out` equals `port_data`.
- R4: On a compare match with `pwm_en` low, the waveform bit changes one cycle later according to `cfg_mode`: 00 keeps it, 01 inverts it, 10 drives it to 0, 11 drives it to 1.
- R5: Writing `cfg_mode` without a match or force changes neither the effective action nor `pin_out`. On the next match the effective action takes the new value, and that match's action uses the new value.
- R6: With `pwm_en` low, a one-cycle `force_strobe` applies the action of the present `cfg_mode` to the waveform bit on the next cycle and loads `cfg_mode` into the effective action.
- R7: With `pwm_en` high, `force_strobe` changes neither the waveform bit nor the effective action, and it is not remembered afterwards.
- R8: A compare match and a force strobe in the same cycle apply the action only once. For example, under 01 the bit inverts exactly once.
- R9: A high `wave_load` puts `wave_load_val` into the waveform bit on the next cycle, whatever the effective action. It takes priority over a match or force in the same cycle.
- R10: With `pwm_en` high, a compare match leaves the waveform bit unchanged but still loads `cfg_mode` into the effective action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Written output-action field (00 keep, 01 invert, 10 to 0, 11 to 1) |
| pwm_en | input | 1 | High while the timer runs a PWM waveform mode |
| cmp_match | input | 1 | One-cycle compare-match pulse from the counter |
| force_strobe | input | 1 | One-cycle request to apply the action immediately |
| wave_load | input | 1 | Load a starting level into the waveform bit |
| wave_load_val | input | 1 | Level loaded by `wave_load` |
| port_data | input | 1 | General-purpose port data bit |
| port_dir | input | 1 | Data-direction bit, 1 means output |
| pin_out | output | 1 | Value driven toward the pad |
| pin_oe | output | 1 | Pad output enable |
| wave_bit | output | 1 | Waveform flip-flop state |

## Verification
The four action codes are each applied on a match from known starting levels. These tests separate keep, invert, to-0 and to-1, including invert from both 0 and 1. During each test `port_data` is set opposite to the waveform bit, so the pin shows whether the override is active. Mode writes without a match show that the effective copy waits for a match. Force strobes with `pwm_en` low and high show that the immediate path applies only in non-PWM operation. A match and a force in the same cycle under invert show the action happens only once, and a load with a conflicting set shows that load wins.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;

    localparam int MODE_W = 2;

    typedef enum logic [MODE_W-1:0] {
        ACT_KEEP   = 2'b00,
        ACT_INVERT = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } cmp_act_e;

    typedef struct packed {
        logic     fire;
        cmp_act_e act;
    } cmp_req_t;

    function automatic logic next_wave(input cmp_act_e act, input logic cur);
        case (act)
            ACT_INVERT: return ~cur;
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/cmp_mode_latch.sv
module cmp_mode_latch
    import cmp_out_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     take,
    input  cmp_act_e new_act,
    output cmp_act_e eff_act
);

    always_ff @(posedge clk) begin
        if (rst)
            eff_act <= ACT_KEEP;
        else if (take)
            eff_act <= new_act;
    end

    // R5: without a take pulse the effective action never moves
    p_eff_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(eff_act));

endmodule

// File: rtl/cmp_wave_ff.sv
module cmp_wave_ff
    import cmp_out_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cmp_req_t req,
    input  logic     load,
    input  logic     load_val,
    output logic     wave
);

    always_ff @(posedge clk) begin
        if (rst)
            wave <= 1'b0;
        else if (load)
            wave <= load_val;
        else if (req.fire)
            wave <= next_wave(req.act, wave);
    end

    p_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (req.fire && req.act == ACT_KEEP && !load) |=> $stable(wave));

    p_invert_r4: assert property (@(posedge clk) disable iff (rst)
        (req.fire && req.act == ACT_INVERT && !load) |=> (wave != $past(wave)));

    p_load_r9: assert property (@(posedge clk) disable iff (rst)
        load |=> (wave == $past(load_val)));

endmodule

// File: rtl/cmp_pin_mux.sv
module cmp_pin_mux
    import cmp_out_pkg::*;
(
    input  cmp_act_e eff_act,
    input  logic     wave,
    input  logic     port_data,
    input  logic     port_dir,
    output logic     pin_out,
    output logic     pin_oe
);

    logic override;

    always_comb begin
        override = (eff_act != ACT_KEEP);
        pin_out  = override ? wave : port_data;
        pin_oe   = port_dir;
    end

endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit
    import cmp_out_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic             pwm_en,
    input  logic             cmp_match,
    input  logic             force_strobe,
    input  logic             wave_load,
    input  logic             wave_load_val,
    input  logic             port_data,
    input  logic             port_dir,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             wave_bit
);

    cmp_act_e cfg_act;
    cmp_act_e eff_act;
    cmp_req_t req;
    logic     force_ok;
    logic     take;

    always_comb begin
        cfg_act  = cmp_act_e'(cfg_mode);
        force_ok = force_strobe && !pwm_en;
        take     = cmp_match || force_ok;
        req.fire = (cmp_match && !pwm_en) || force_ok;
        req.act  = cfg_act;
    end

    cmp_mode_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .new_act (cfg_act),
        .eff_act (eff_act)
    );

    cmp_wave_ff u_wave (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .load     (wave_load),
        .load_val (wave_load_val),
        .wave     (wave_bit)
    );

    cmp_pin_mux u_mux (
        .eff_act   (eff_act),
        .wave      (wave_bit),
        .port_data (port_data),
        .port_dir  (port_dir),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    // R7: a force during PWM leaves the waveform alone
    p_force_pwm_r7: assert property (@(posedge clk) disable iff (rst)
        (force_strobe && pwm_en && !cmp_match && !wave_load) |=> $stable(wave_bit));

    // R10: a match during PWM leaves the waveform alone
    p_match_pwm_r10: assert property (@(posedge clk) disable iff (rst)
        (cmp_match && pwm_en && !wave_load) |=> $stable(wave_bit));

    // R1: the cycle after reset starts from a low waveform bit
    p_reset_low_r1: assert property (@(posedge clk)
        $past(rst) |-> !wave_bit);

endmodule

// File: tb/cmp_out_unit_bench.sv
module cmp_out_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] cfg_mode = 2'b00;
    logic       pwm_en = 1'b0;
    logic       cmp_match = 1'b0;
    logic       force_strobe = 1'b0;
    logic       wave_load = 1'b0;
    logic       wave_load_val = 1'b0;
    logic       port_data = 1'b0;
    logic       port_dir = 1'b1;
    logic       pin_out, pin_oe, wave_bit;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cmp_out_unit u_cmp_out_unit (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .pwm_en(pwm_en),
        .cmp_match(cmp_match), .force_strobe(force_strobe),
        .wave_load(wave_load), .wave_load_val(wave_load_val),
        .port_data(port_data), .port_dir(port_dir),
        .pin_out(pin_out), .pin_oe(pin_oe), .wave_bit(wave_bit)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        cmp_match = 1'b0;
        force_strobe = 1'b0;
        wave_load = 1'b0;
    endtask

    task automatic pulse_match(input logic [1:0] m);
        cfg_mode = m;
        cmp_match = 1'b1;
        step();
    endtask

    task automatic t_reset();
        port_data = 1'b1;
        port_dir = 1'b1;
        repeat (3) step();
        chk("R1 wave in reset", wave_bit, 1'b0);
        chk("R1 pin in reset", pin_out, 1'b1);
        rst = 1'b0;
        step();
        chk("R1 wave after reset", wave_bit, 1'b0);
        chk("R2 oe dir=1", pin_oe, 1'b1);
    endtask

    task automatic t_preload();
        port_data = 1'b0;
        wave_load = 1'b1;
        wave_load_val = 1'b1;
        step();
        chk("R9 preload wave", wave_bit, 1'b1);
        chk("R3 no override while keep", pin_out, 1'b0);
    endtask

    task automatic t_deferred_mode();
        cfg_mode = 2'b01;
        step();
        step();
        chk("R5 write alone no override", pin_out, 1'b0);
        chk("R5 write alone wave", wave_bit, 1'b1);
        port_data = 1'b1;
        pulse_match(2'b01);
        chk("R4 invert 1->0", wave_bit, 1'b0);
        chk("R5 override after match", pin_out, 1'b0);
    endtask

    task automatic t_actions();
        pulse_match(2'b01);
        chk("R4 invert 0->1", wave_bit, 1'b1);
        chk("R3 pin follows wave", pin_out, 1'b1);
        pulse_match(2'b10);
        chk("R4 to-low", wave_bit, 1'b0);
        pulse_match(2'b11);
        chk("R4 to-high", wave_bit, 1'b1);
        port_data = 1'b0;
        pulse_match(2'b00);
        chk("R4 keep", wave_bit, 1'b1);
        chk("R3 keep releases pin", pin_out, 1'b0);
        port_dir = 1'b0;
        step();
        chk("R2 oe dir=0", pin_oe, 1'b0);
        port_dir = 1'b1;
    endtask

    task automatic t_force();
        port_data = 1'b1;
        cfg_mode = 2'b10;
        force_strobe = 1'b1;
        step();
        chk("R6 force to-low", wave_bit, 1'b0);
        chk("R6 force loads override", pin_out, 1'b0);
        pwm_en = 1'b1;
        cfg_mode = 2'b11;
        force_strobe = 1'b1;
        step();
        chk("R7 pwm force wave", wave_bit, 1'b0);
        cfg_mode = 2'b00;
        force_strobe = 1'b1;
        step();
        chk("R7 pwm force keeps override", pin_out, 1'b0);
        step();
        chk("R7 force not remembered", wave_bit, 1'b0);
    endtask

    task automatic t_pwm_match();
        pulse_match(2'b11);
        chk("R10 pwm match wave held", wave_bit, 1'b0);
        pulse_match(2'b00);
        chk("R10 pwm match latches mode", pin_out, 1'b1);
        pwm_en = 1'b0;
    endtask

    task automatic t_both_and_load();
        cfg_mode = 2'b01;
        force_strobe = 1'b1;
        step();
        chk("R6 force invert", wave_bit, 1'b1);
        cfg_mode = 2'b01;
        cmp_match = 1'b1;
        force_strobe = 1'b1;
        step();
        chk("R8 match+force once", wave_bit, 1'b0);
        cfg_mode = 2'b11;
        cmp_match = 1'b1;
        wave_load = 1'b1;
        wave_load_val = 1'b0;
        step();
        chk("R9 load beats set", wave_bit, 1'b0);
    endtask

    task automatic t_rereset();
        rst = 1'b1;
        step();
        rst = 1'b0;
        port_data = 1'b1;
        step();
        chk("R1 rereset pin=port", pin_out, 1'b1);
        chk("R1 rereset wave", wave_bit, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_preload();
        t_deferred_mode();
        t_actions();
        t_force();
        t_pwm_match();
        t_both_and_load();
        t_rereset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule